// File: doc/BRIEF.md
# Two-Subphase Address Parity Unit

This block produces and verifies the two address-parity wires of a processor bus request. A request occupies two consecutive clocks. In the first clock the 33 address/type wires carry address bits 35 down to 3. In the second clock the same wires carry the transaction type. Every bus wire is active-low. A parity wire is defined by how many of the wires it covers are low: an even count drives it high and an odd count drives it low. The set of wires that each parity bit covers is exchanged between the two subphases.

On the sending side, the block drives both parity wires combinationally from the present address/type and request fields. A subphase select input chooses the grouping. On the receiving side, an asserted (low) address strobe marks the first subphase of a new request. The block compares the received parity wires against the expected values in that cycle and in the cycle after it. It raises a one-clock error flag for each parity wire in each subphase.

Top module: `addr_parity_unit`

## Requirements
- R1: Each driven parity wire is 1 (high) when the wires it covers hold an even number of 0 (low) levels, and 0 when that number is odd.
- R2: When every covered address/type and request wire is 1, both driven parity wires are 1 in either subphase.
- R3: With `phase2` = 0, `par_drv_n[0]` covers `addr_n[32:21]` (address bits 35..24), and `par_drv_n[1]` covers `addr_n[20:0]` together with all of `req_n`.
- R4: With `phase2` = 1 the grouping is exchanged: `par_drv_n[1]` covers `addr_n[32:21]`, and `par_drv_n[0]` covers `addr_n[20:0]` plus `req_n`.
- R5: While `rst` is 1, `par_drv_n` is 2'b11. After a clock edge with `rst` at 1, `err_sp1` and `err_sp2` are 0.
- R6: A clock edge that samples `strobe_n` = 0 while no request is in progress treats that cycle as subphase 1. For one clock after that edge, `err_sp1[k]` is 1 exactly when `par_in_n[k]` differed from the subphase-1 expected value of wire k.
- R7: The cycle directly after a subphase-1 cycle is subphase 2. It is checked with the exchanged grouping, and `err_sp2[k]` is 1 for the one clock after it exactly when `par_in_n[k]` was wrong.
- R8: A `strobe_n` of 0 during subphase 2 does not start a new request. No `err_sp1` flag follows that cycle, whatever the parity inputs are.
- R9: Outside a request's two subphases, the parity inputs never raise any error flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe_n | input | 1 | Address strobe, active low, marks subphase 1 |
| phase2 | input | 1 | Sending side: 0 selects subphase-1 grouping, 1 selects subphase-2 grouping |
| addr_n | input | 33 | Address/type wires (bit 0 is address bit 3) |
| req_n | input | 5 | Request wires |
| par_in_n | input | 2 | Received parity wires |
| par_drv_n | output | 2 | Driven parity wires |
| err_sp1 | output | 2 | Per-wire parity error for subphase 1, one-clock pulse |
| err_sp2 | output | 2 | Per-wire parity error for subphase 2, one-clock pulse |

## Verification
The bench pulls each of the 38 covered wires low on its own, in both subphases. A design that split the groups at the wrong bit, or forgot to exchange them, would drop the wrong parity wire low. Random fields are compared against a count of low levels made in the bench, which exposes an inverted polarity. Receiver requests flip each received parity bit in each subphase, so that a flag on the wrong wire or in the wrong cycle shows up. A strobe held low through subphase 2 with deliberately bad subphase-1 parity catches a design that restarts a request there. Idle cycles with junk parity catch a receiver that checks without a strobe.

// File: rtl/addr_parity_unit.sv
module addr_parity_unit #(
  parameter int ADDR_W = 33,
  parameter int REQ_W  = 5,
  parameter int HI_W   = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_n,
  input  logic              phase2,
  input  logic [ADDR_W-1:0] addr_n,
  input  logic [REQ_W-1:0]  req_n,
  input  logic [1:0]        par_in_n,
  output logic [1:0]        par_drv_n,
  output logic [1:0]        err_sp1,
  output logic [1:0]        err_sp2
);
  localparam int LO_W = ADDR_W - HI_W;

  logic       hi_even, lo_even, in_sp2;
  logic [1:0] exp_sp1, exp_sp2;

  assign hi_even = ~^(~addr_n[ADDR_W-1:LO_W]);
  assign lo_even = ~^(~{addr_n[LO_W-1:0], req_n});

  assign exp_sp1 = {lo_even, hi_even};
  assign exp_sp2 = {hi_even, lo_even};

  assign par_drv_n = rst ? 2'b11 : (phase2 ? exp_sp2 : exp_sp1);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_sp2  <= 1'b0;
      err_sp1 <= 2'b00;
      err_sp2 <= 2'b00;
    end else begin
      in_sp2  <= !in_sp2 && !strobe_n;
      err_sp1 <= (!in_sp2 && !strobe_n) ? (par_in_n ^ exp_sp1) : 2'b00;
      err_sp2 <= in_sp2 ? (par_in_n ^ exp_sp2) : 2'b00;
    end
  end
endmodule

module addr_parity_unit_chk #(
  parameter int ADDR_W = 33,
  parameter int REQ_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              strobe_n,
  input logic              phase2,
  input logic [ADDR_W-1:0] addr_n,
  input logic [REQ_W-1:0]  req_n,
  input logic [1:0]        par_drv_n,
  input logic [1:0]        err_sp1,
  input logic [1:0]        err_sp2
);
  AST_RST_IDLE: assert property (@(posedge clk) rst |-> par_drv_n == 2'b11); // R5
  AST_ALL_HIGH: assert property (@(posedge clk) disable iff (rst)
    (&addr_n && &req_n) |-> par_drv_n == 2'b11); // R2
  AST_SWAP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(addr_n) && $stable(req_n) && phase2 != $past(phase2))
    |-> par_drv_n == {$past(par_drv_n[0]), $past(par_drv_n[1])}); // R4
  AST_SP1_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (|err_sp1) |=> err_sp1 == 2'b00); // R8
  AST_SP2_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    (|err_sp2) |-> $past(strobe_n, 2) == 1'b0); // R7
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !((|err_sp1) && (|err_sp2))); // R6
endmodule

bind addr_parity_unit addr_parity_unit_chk #(.ADDR_W(ADDR_W), .REQ_W(REQ_W)) u_chk (
  .clk(clk), .rst(rst), .strobe_n(strobe_n), .phase2(phase2), .addr_n(addr_n),
  .req_n(req_n), .par_drv_n(par_drv_n), .err_sp1(err_sp1), .err_sp2(err_sp2)
);

// File: tb/test_addr_parity_unit.sv
`timescale 1ns/1ps
module test_addr_parity_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strobe_n = 1'b1;
  logic        phase2 = 1'b0;
  logic [32:0] addr_n = '1;
  logic [4:0]  req_n = '1;
  logic [1:0]  par_in_n = 2'b11;
  logic [1:0]  par_drv_n, err_sp1, err_sp2;
  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  addr_parity_unit i_addr_parity_unit (
    .clk(clk), .rst(rst), .strobe_n(strobe_n), .phase2(phase2), .addr_n(addr_n),
    .req_n(req_n), .par_in_n(par_in_n), .par_drv_n(par_drv_n),
    .err_sp1(err_sp1), .err_sp2(err_sp2)
  );

  function automatic logic [1:0] ref_par(logic [32:0] a, logic [4:0] r, logic ph);
    int hi_low = 0;
    int lo_low = 0;
    logic hi, lo;
    for (int i = 21; i < 33; i++) if (a[i] == 1'b0) hi_low++;
    for (int i = 0; i < 21; i++) if (a[i] == 1'b0) lo_low++;
    for (int i = 0; i < 5; i++) if (r[i] == 1'b0) lo_low++;
    hi = (hi_low % 2 == 0);
    lo = (lo_low % 2 == 0);
    return ph ? {hi, lo} : {lo, hi};
  endfunction

  task automatic check2(string tag, logic [1:0] act, logic [1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic txn(logic [32:0] a1, logic [4:0] r1, logic [1:0] p1,
                     logic [32:0] a2, logic [4:0] r2, logic [1:0] p2, bit strobe2);
    strobe_n = 1'b0; addr_n = a1; req_n = r1; par_in_n = p1;
    tick();
    check2("R6 sp1 flags", err_sp1, p1 ^ ref_par(a1, r1, 1'b0));
    check2("R6 sp2 quiet", err_sp2, 2'b00);
    strobe_n = strobe2 ? 1'b0 : 1'b1; addr_n = a2; req_n = r2; par_in_n = p2;
    tick();
    check2("R7 sp2 flags", err_sp2, p2 ^ ref_par(a2, r2, 1'b1));
    check2("R7 sp1 quiet", err_sp1, 2'b00);
    strobe_n = 1'b1; par_in_n = 2'b10;
    tick();
    check2("R8 no restart sp1", err_sp1, 2'b00);
    check2("R9 idle sp2", err_sp2, 2'b00);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    addr_n = 33'h0; req_n = 5'h03; par_in_n = 2'b00; strobe_n = 1'b0;
    tick(); tick();
    check2("R5 reset drive", par_drv_n, 2'b11);
    check2("R5 reset sp1", err_sp1, 2'b00);
    check2("R5 reset sp2", err_sp2, 2'b00);
    strobe_n = 1'b1;
    tick();
    rst = 1'b0;
    tick();

    addr_n = '1; req_n = '1;
    for (int ph = 0; ph < 2; ph++) begin
      phase2 = ph[0];
      #1 check2("R2 all high", par_drv_n, 2'b11);
    end

    phase2 = 1'b0; addr_n = '1; addr_n[21] = 1'b0;
    #1 check2("R3 bit 24 low sp1", par_drv_n, 2'b10);
    addr_n = '1; addr_n[20] = 1'b0;
    #1 check2("R3 bit 23 low sp1", par_drv_n, 2'b01);
    addr_n = '1; req_n = 5'b11110;
    #1 check2("R3 req low sp1", par_drv_n, 2'b01);
    phase2 = 1'b1;
    #1 check2("R4 req low sp2", par_drv_n, 2'b10);
    req_n = '1; addr_n[32] = 1'b0;
    #1 check2("R4 bit 35 low sp2", par_drv_n, 2'b01);

    for (int ph = 0; ph < 2; ph++) begin
      for (int i = 0; i < 38; i++) begin
        logic [37:0] v;
        v = ~(38'b1 << i);
        phase2 = ph[0]; addr_n = v[37:5]; req_n = v[4:0];
        #1 check2(ph ? "R4 single low" : "R3 single low", par_drv_n,
                  ref_par(v[37:5], v[4:0], ph[0]));
      end
    end

    for (int n = 0; n < 300; n++) begin
      logic [32:0] a;
      logic [4:0]  r;
      a = {$urandom_range(1, 0) == 1, $urandom()};
      r = 5'($urandom());
      phase2 = n[0]; addr_n = a; req_n = r;
      #1 check2("R1 random parity", par_drv_n, ref_par(a, r, n[0]));
    end
    phase2 = 1'b0;
    tick();

    for (int n = 0; n < 40; n++) begin
      logic [32:0] a1, a2;
      logic [4:0]  r1, r2;
      logic [1:0]  e1, e2;
      a1 = {$urandom_range(1, 0) == 1, $urandom()};
      a2 = {$urandom_range(1, 0) == 1, $urandom()};
      r1 = 5'($urandom()); r2 = 5'($urandom());
      e1 = ref_par(a1, r1, 1'b0);
      e2 = ref_par(a2, r2, 1'b1);
      txn(a1, r1, e1 ^ 2'(n % 4), a2, r2, e2 ^ 2'((n / 4) % 4), 1'b0);
    end

    for (int n = 0; n < 20; n++) begin
      logic [32:0] a1, a2;
      logic [4:0]  r1, r2;
      a1 = {$urandom_range(1, 0) == 1, $urandom()};
      a2 = {$urandom_range(1, 0) == 1, $urandom()};
      r1 = 5'($urandom()); r2 = 5'($urandom());
      txn(a1, r1, ref_par(a1, r1, 1'b0), a2, r2, ~ref_par(a2, r2, 1'b0), 1'b1);
    end

    strobe_n = 1'b1;
    for (int n = 0; n < 8; n++) begin
      par_in_n = 2'(n); addr_n = {$urandom_range(1, 0) == 1, $urandom()};
      tick();
      check2("R9 idle sp1", err_sp1, 2'b00);
      check2("R9 idle sp2", err_sp2, 2'b00);
    end

    rst = 1'b1;
    #1 check2("R5 reset drive again", par_drv_n, 2'b11);
    tick();
    check2("R5 reset clears", err_sp1 | err_sp2, 2'b00);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule